// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block sits in a two-wide decode stage. It maps architectural register numbers onto a larger pool of physical registers. It keeps three pieces of state: a mapping table with one entry per architectural register, a circular free list of physical registers that are not allocated, and one presence bit per physical register. The bit is set once that register's value has been produced.

Each cycle, up to two instructions arrive in program order, in slot 0 and then slot 1. For each instruction the block returns:
- the physical tags of its two sources, each with a ready flag;
- a freshly allocated physical destination;
- the physical register that the destination was mapped to before this rename.

The reorder buffer keeps that old mapping. When the instruction commits, the old mapping comes back on the commit port and is pushed onto the free list. A writeback port marks physical registers as present.

At a predicted branch, a checkpoint port stores the mapping table together with the free-list read pointer. When the branch mispredicts, the stored copy is restored. All registers allocated after the branch then return to the free list.

Data values, reorder-buffer storage and issue selection are handled elsewhere. The parameter `NUM_PHYS` must be a power of two.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i with its presence bit set. The free list holds physical registers `NUM_ARCH` up to `NUM_PHYS-1` in ascending order, so the first allocations are `NUM_ARCH`, `NUM_ARCH+1`, and so on.
- R2: A source tag is the current mapping-table entry of its architectural register.
- R3: A slot with both `in_vld` and `in_wr` high receives the physical register at the head of the free list. Slot 0 takes the head entry first, and slot 1 takes the next entry. The presence bit of an allocated register is cleared.
- R4: `out_prev` of a writing slot is the mapping its destination held before this rename. The table then holds the new physical destination.
- R5: If slot 1 reads the destination register of a writing slot 0 in the same cycle, that source gets slot 0's new physical destination with its ready flag low.
- R6: If both slots write the same architectural register, slot 1's `out_prev` is slot 0's new destination, and the table ends up holding slot 1's destination.
- R7: `ren_ready` is low when the free list holds fewer registers than the number of writing slots. While `ren_ready` is low, nothing is allocated and the mapping table is unchanged.
- R8: Each `cm_vld` bit pushes its `cm_tag` onto the tail of the free list, slot 0 before slot 1. The pushed registers are handed out again in that order.
- R9: A source's ready flag is the presence bit of its tag, OR any same-cycle writeback of that tag. A writeback sets the presence bit from the next cycle on.
- R10: `ck_save` stores the mapping table and free-list head as they are after this cycle's renames. `ck_restore` reloads both from the selected slot and holds `ren_ready` low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 2 | Slot holds an instruction |
| in_wr | input | 2 | Slot writes a destination register |
| in_dst | input | 2 x AW | Architectural destination per slot |
| in_src_a | input | 2 x AW | First architectural source per slot |
| in_src_b | input | 2 x AW | Second architectural source per slot |
| ren_ready | output | 1 | Slots are renamed this cycle |
| out_tag_a | output | 2 x PW | Physical tag of first source |
| out_rdy_a | output | 2 | First source value present |
| out_tag_b | output | 2 x PW | Physical tag of second source |
| out_rdy_b | output | 2 | Second source value present |
| out_pdst | output | 2 x PW | Newly allocated physical destination |
| out_prev | output | 2 x PW | Previous mapping of the destination |
| wb_vld | input | NUM_WB | Writeback broadcast valid |
| wb_tag | input | NUM_WB x PW | Physical tag written back |
| cm_vld | input | 2 | Commit returns a register |
| cm_tag | input | 2 x PW | Physical register returned to the free list |
| ck_save | input | 1 | Store a checkpoint |
| ck_save_id | input | CW | Checkpoint slot to store |
| ck_restore | input | 1 | Restore a checkpoint |
| ck_restore_id | input | CW | Checkpoint slot to restore |

## Verification
Allocation and reclamation can both happen in the same cycle. Commits push registers onto the tail of the free list while renames pop from its head. Writeback broadcasts can also coincide with source lookups of the same tags.

The bench provokes all three. It mixes random commits of pending old mappings and random writeback tags into random rename pairs over a small register range, so that pairs often read or write each other's registers. A directed run also drains the free list to zero and then refills it one register at a time.

A bench model of the mapping table, free list and presence bits predicts every tag and flag, and each output is compared before the clock edge that consumes it.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 64,
  parameter int NUM_CKPT = 4,
  parameter int NUM_WB   = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS),
  localparam int CW = (NUM_CKPT > 1) ? $clog2(NUM_CKPT) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   in_vld,
  input  logic [1:0]                   in_wr,
  input  logic [1:0][AW-1:0]           in_dst,
  input  logic [1:0][AW-1:0]           in_src_a,
  input  logic [1:0][AW-1:0]           in_src_b,
  output logic                         ren_ready,
  output logic [1:0][PW-1:0]           out_tag_a,
  output logic [1:0]                   out_rdy_a,
  output logic [1:0][PW-1:0]           out_tag_b,
  output logic [1:0]                   out_rdy_b,
  output logic [1:0][PW-1:0]           out_pdst,
  output logic [1:0][PW-1:0]           out_prev,
  input  logic [NUM_WB-1:0]            wb_vld,
  input  logic [NUM_WB-1:0][PW-1:0]    wb_tag,
  input  logic [1:0]                   cm_vld,
  input  logic [1:0][PW-1:0]           cm_tag,
  input  logic                         ck_save,
  input  logic [CW-1:0]                ck_save_id,
  input  logic                         ck_restore,
  input  logic [CW-1:0]                ck_restore_id
);

  localparam int FREE_INIT = NUM_PHYS - NUM_ARCH;

  logic [PW-1:0] map_q [NUM_ARCH];
  logic [PW-1:0] map_d [NUM_ARCH];
  logic [PW-1:0] snap_map [NUM_CKPT][NUM_ARCH];
  logic [PW:0]   snap_head [NUM_CKPT];
  logic [PW-1:0] fl_mem [NUM_PHYS];
  logic [PW:0]   head_q, head_d, tail_q, fl_cnt;
  logic [NUM_PHYS-1:0] pres_q;

  logic a0, a1, al0, al1;
  logic [1:0] need;
  logic fwd_a, fwd_b, same_dst;

  assign a0   = in_vld[0] & in_wr[0];
  assign a1   = in_vld[1] & in_wr[1];
  assign need = {1'b0, a0} + {1'b0, a1};
  assign fl_cnt = tail_q - head_q;
  assign ren_ready = !ck_restore && (fl_cnt >= (PW+1)'(need));
  assign al0 = a0 & ren_ready;
  assign al1 = a1 & ren_ready;
  assign head_d = head_q + (PW+1)'(al0) + (PW+1)'(al1);

  assign out_pdst[0] = fl_mem[head_q[PW-1:0]];
  assign out_pdst[1] = fl_mem[head_q[PW-1:0] + PW'(a0)];

  assign fwd_a    = a0 && (in_src_a[1] == in_dst[0]);
  assign fwd_b    = a0 && (in_src_b[1] == in_dst[0]);
  assign same_dst = a0 && (in_dst[1] == in_dst[0]);

  function automatic logic wb_hit(input logic [PW-1:0] t);
    logic h;
    h = 1'b0;
    for (int k = 0; k < NUM_WB; k++)
      if (wb_vld[k] && wb_tag[k] == t) h = 1'b1;
    return h;
  endfunction

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      out_tag_a[s] = map_q[in_src_a[s]];
      out_tag_b[s] = map_q[in_src_b[s]];
      out_prev[s]  = map_q[in_dst[s]];
    end
    if (fwd_a)    out_tag_a[1] = out_pdst[0];
    if (fwd_b)    out_tag_b[1] = out_pdst[0];
    if (same_dst) out_prev[1]  = out_pdst[0];
    for (int s = 0; s < 2; s++) begin
      out_rdy_a[s] = pres_q[out_tag_a[s]] | wb_hit(out_tag_a[s]);
      out_rdy_b[s] = pres_q[out_tag_b[s]] | wb_hit(out_tag_b[s]);
    end
    if (fwd_a) out_rdy_a[1] = 1'b0;
    if (fwd_b) out_rdy_b[1] = 1'b0;
  end

  always_comb begin
    map_d = map_q;
    if (al0) map_d[in_dst[0]] = out_pdst[0];
    if (al1) map_d[in_dst[1]] = out_pdst[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= PW'(i);
    end else if (ck_restore) begin
      map_q <= snap_map[ck_restore_id];
    end else begin
      map_q <= map_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ck_save) begin
      snap_map[ck_save_id]  <= map_d;
      snap_head[ck_save_id] <= head_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        fl_mem[i] <= (i < FREE_INIT) ? PW'(NUM_ARCH + i) : '0;
      head_q <= '0;
      tail_q <= (PW+1)'(FREE_INIT);
    end else begin
      head_q <= ck_restore ? snap_head[ck_restore_id] : head_d;
      if (cm_vld[0]) fl_mem[tail_q[PW-1:0]] <= cm_tag[0];
      if (cm_vld[1]) fl_mem[tail_q[PW-1:0] + PW'(cm_vld[0])] <= cm_tag[1];
      tail_q <= tail_q + (PW+1)'(cm_vld[0]) + (PW+1)'(cm_vld[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++) pres_q[i] <= (i < NUM_ARCH);
    end else begin
      for (int k = 0; k < NUM_WB; k++)
        if (wb_vld[k]) pres_q[wb_tag[k]] <= 1'b1;
      if (al0) pres_q[out_pdst[0]] <= 1'b0;
      if (al1) pres_q[out_pdst[1]] <= 1'b0;
    end
  end

  AST_FL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cnt <= (PW+1)'(FREE_INIT)); // R8
  AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    (al0 && al1) |-> out_pdst[0] != out_pdst[1]); // R3
  AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    al0 |=> !pres_q[$past(out_pdst[0])]); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ck_restore && !al0 && !al1) |=> head_q == $past(head_q)); // R7
  AST_TABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    al1 |=> map_q[$past(in_dst[1])] == $past(out_pdst[1])); // R6
  AST_WB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld[0] && !(al0 && out_pdst[0] == wb_tag[0]) && !(al1 && out_pdst[1] == wb_tag[0]))
      |=> pres_q[$past(wb_tag[0])]); // R9
  AST_RESTORE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    ck_restore |-> !ren_ready); // R10

endmodule

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
  localparam int NA = 32, NP = 64, NC = 4, NW = 2;
  localparam int AW = $clog2(NA), PW = $clog2(NP), CW = $clog2(NC);

  logic clk = 0, rst_n = 0;
  logic [1:0] in_vld, in_wr, cm_vld, out_rdy_a, out_rdy_b;
  logic [1:0][AW-1:0] in_dst, in_src_a, in_src_b;
  logic ren_ready, ck_save, ck_restore;
  logic [1:0][PW-1:0] out_tag_a, out_tag_b, out_pdst, out_prev, cm_tag;
  logic [NW-1:0] wb_vld;
  logic [NW-1:0][PW-1:0] wb_tag;
  logic [CW-1:0] ck_save_id, ck_restore_id;

  reg_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_CKPT(NC), .NUM_WB(NW)) u_reg_rename (
    .clk, .rst_n, .in_vld, .in_wr, .in_dst, .in_src_a, .in_src_b, .ren_ready,
    .out_tag_a, .out_rdy_a, .out_tag_b, .out_rdy_b, .out_pdst, .out_prev,
    .wb_vld, .wb_tag, .cm_vld, .cm_tag, .ck_save, .ck_save_id, .ck_restore, .ck_restore_id);

  always #4 clk = ~clk;

  int n_vec = 0, n_err = 0;
  bit done = 0, after_restore = 0;
  int m_map [NA];
  bit m_pres [NP];
  int m_fl [NP];
  int m_head, m_tail;
  int s_map [NC][NA];
  int s_head [NC], s_pend [NC];
  int pend [256];
  int pend_rd, pend_wr;

  task automatic chk(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic string lb(input string d);
    return after_restore ? "R10" : d;
  endfunction

  function automatic bit wbhit(input int t);
    for (int k = 0; k < NW; k++) if (wb_vld[k] && int'(wb_tag[k]) == t) return 1;
    return 0;
  endfunction

  task automatic idle();
    in_vld = 0; in_wr = 0; in_dst = '0; in_src_a = '0; in_src_b = '0;
    wb_vld = 0; wb_tag = '0; cm_vld = 0; cm_tag = '0;
    ck_save = 0; ck_save_id = 0; ck_restore = 0; ck_restore_id = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) m_map[i] = i;
    for (int i = 0; i < NP; i++) begin
      m_pres[i] = (i < NA);
      m_fl[i] = (i < NP - NA) ? NA + i : 0;
    end
    m_head = 0; m_tail = NP - NA; pend_rd = 0; pend_wr = 0;
  endtask

  task automatic model_update(input bit rdy, input bit a0, input bit a1, input int pd0, input int pd1);
    bit restored = 0;
    if (ck_restore) begin
      for (int i = 0; i < NA; i++) m_map[i] = s_map[ck_restore_id][i];
      m_head = s_head[ck_restore_id];
      pend_wr = s_pend[ck_restore_id];
      restored = 1;
    end
    for (int k = 0; k < NW; k++) if (wb_vld[k]) m_pres[wb_tag[k]] = 1;
    if (rdy && a0) begin
      pend[pend_wr % 256] = m_map[in_dst[0]]; pend_wr++;
      m_map[in_dst[0]] = pd0; m_pres[pd0] = 0; m_head++;
    end
    if (rdy && a1) begin
      pend[pend_wr % 256] = m_map[in_dst[1]]; pend_wr++;
      m_map[in_dst[1]] = pd1; m_pres[pd1] = 0; m_head++;
    end
    for (int c = 0; c < 2; c++) if (cm_vld[c]) begin
      m_fl[m_tail % NP] = cm_tag[c]; m_tail++; pend_rd++;
    end
    if (ck_save) begin
      for (int i = 0; i < NA; i++) s_map[ck_save_id][i] = m_map[i];
      s_head[ck_save_id] = m_head;
      s_pend[ck_save_id] = pend_wr;
    end
    after_restore = restored;
  endtask

  task automatic cycle();
    bit a0, a1, rdy, r;
    int pd0, pd1, t;
    #1;
    a0 = in_vld[0] && in_wr[0];
    a1 = in_vld[1] && in_wr[1];
    rdy = !ck_restore && ((m_tail - m_head) >= (int'(a0) + int'(a1)));
    chk(lb("R7"), ren_ready, rdy);
    pd0 = m_fl[m_head % NP];
    pd1 = m_fl[(m_head + int'(a0)) % NP];
    for (int s = 0; s < 2; s++) begin
      if (s == 1 && a0 && in_src_a[1] == in_dst[0]) begin
        chk(lb("R5"), out_tag_a[1], pd0); chk(lb("R5"), out_rdy_a[1], 0);
      end else begin
        t = m_map[in_src_a[s]]; r = m_pres[t] || wbhit(t);
        chk(lb("R2"), out_tag_a[s], t); chk(lb("R9"), out_rdy_a[s], r);
      end
      if (s == 1 && a0 && in_src_b[1] == in_dst[0]) begin
        chk(lb("R5"), out_tag_b[1], pd0); chk(lb("R5"), out_rdy_b[1], 0);
      end else begin
        t = m_map[in_src_b[s]]; r = m_pres[t] || wbhit(t);
        chk(lb("R2"), out_tag_b[s], t); chk(lb("R9"), out_rdy_b[s], r);
      end
    end
    if (rdy && a0) chk(lb(m_head >= NP - NA ? "R8" : "R3"), out_pdst[0], pd0);
    if (rdy && a1) chk(lb(m_head + int'(a0) >= NP - NA ? "R8" : "R3"), out_pdst[1], pd1);
    if (a0) chk(lb("R4"), out_prev[0], m_map[in_dst[0]]);
    if (a1) begin
      if (a0 && in_dst[1] == in_dst[0]) chk(lb("R6"), out_prev[1], pd0);
      else chk(lb("R4"), out_prev[1], m_map[in_dst[1]]);
    end
    @(posedge clk);
    model_update(rdy, a0, a1, pd0, pd1);
    @(negedge clk);
  endtask

  task automatic drive_commits(input int want);
    int n = pend_wr - pend_rd;
    if (want < n) n = want;
    cm_vld = 0;
    if (n >= 1) begin cm_vld[0] = 1; cm_tag[0] = PW'(pend[pend_rd % 256]); end
    if (n >= 2) begin cm_vld[1] = 1; cm_tag[1] = PW'(pend[(pend_rd + 1) % 256]); end
  endtask

  task automatic drain();
    while (pend_wr != pend_rd) begin
      idle(); drive_commits(2); cycle();
    end
    idle();
  endtask

  task automatic rand_rename(input int hi);
    in_vld = 2'($urandom_range(0, 3));
    in_wr  = 2'($urandom_range(0, 3));
    for (int s = 0; s < 2; s++) begin
      in_dst[s]   = AW'($urandom_range(0, hi));
      in_src_a[s] = AW'($urandom_range(0, hi));
      in_src_b[s] = AW'($urandom_range(0, hi));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    idle(); model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset mapping and presence
    for (int i = 0; i < 8; i++) begin
      in_src_a[0] = AW'(i * 4); in_src_b[1] = AW'(i * 4 + 1);
      #1;
      chk("R1", out_tag_a[0], i * 4); chk("R1", out_rdy_a[0], 1);
      chk("R1", out_tag_b[1], i * 4 + 1); chk("R1", out_rdy_b[1], 1);
    end
    in_vld = 3; in_wr = 3; in_dst[0] = 3; in_dst[1] = 7; in_src_a[1] = 3;
    #1;
    chk("R1", out_pdst[0], NA); chk("R1", out_pdst[1], NA + 1);
    chk("R1", out_prev[0], 3); chk("R1", out_prev[1], 7);
    cycle();
    // R6: same destination in both slots
    idle(); in_vld = 3; in_wr = 3; in_dst[0] = 5; in_dst[1] = 5; in_src_a[0] = 5;
    cycle();
    idle(); in_vld = 1; in_src_a[0] = 5; in_src_b[0] = 3;
    #1; chk("R6", out_tag_a[0], NA + 3);
    cycle();
    // R9: writeback forwarding and setting
    idle(); in_vld = 1; in_src_a[0] = 5; wb_vld = 1; wb_tag[0] = PW'(NA + 3);
    #1; chk("R9", out_rdy_a[0], 1);
    cycle();
    idle(); in_vld = 1; in_src_a[0] = 5;
    #1; chk("R9", out_rdy_a[0], 1);
    cycle();
    drain();
    // R7: exhaust the free list, then refill
    for (int c = 0; c < 20; c++) begin
      idle(); in_vld = 3; in_wr = 3;
      in_dst[0] = AW'($urandom_range(0, 31)); in_dst[1] = AW'($urandom_range(0, 31));
      cycle();
    end
    idle(); in_vld = 3; in_wr = 3; #1; chk("R7", ren_ready, 0);
    idle(); drive_commits(1); cycle();
    idle(); in_vld = 3; in_wr = 3; in_dst[0] = 9; #1; chk("R7", ren_ready, 0);
    cycle();
    idle(); in_vld = 1; in_wr = 1; in_dst[0] = 9; #1; chk("R7", ren_ready, 1);
    cycle();
    drain();
    // R10: checkpoint save, speculative renames, restore
    for (int rep = 0; rep < 2; rep++) begin
      idle(); in_vld = 3; in_wr = 3; in_dst[0] = 4; in_dst[1] = 9;
      ck_save = 1; ck_save_id = CW'(rep + 1);
      cycle();
      for (int c = 0; c < 3; c++) begin
        idle(); in_vld = 3; in_wr = 3; in_dst[0] = 4; in_dst[1] = AW'(c);
        cycle();
      end
      idle(); in_vld = 3; in_wr = 3; ck_restore = 1; ck_restore_id = CW'(rep + 1);
      #1; chk("R10", ren_ready, 0);
      cycle();
      idle(); in_vld = 3; in_wr = 3; in_dst[0] = 11; in_src_a[0] = 4; in_src_b[0] = 9;
      in_src_a[1] = 1;
      cycle();
      drain();
    end
    // random mix
    for (int c = 0; c < 4000; c++) begin
      idle();
      rand_rename(($urandom_range(0, 3) == 0) ? 31 : 7);
      for (int k = 0; k < NW; k++) begin
        wb_vld[k] = ($urandom_range(0, 2) == 0);
        wb_tag[k] = PW'($urandom_range(0, NP - 1));
      end
      drive_commits((m_tail - m_head < 6) ? 2 : $urandom_range(0, 2));
      cycle();
    end
    drain();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule